// File: doc/BRIEF.md
# Register-Write Command Batcher Engine

This block runs a prepared list of register accesses against an attached serial-bus controller so that a processor does not have to perform every access itself. Software loads an opcode table and a payload table through a word-addressed configuration port, enables the engine and then pulses a start bit. The engine takes one opcode at a time and pairs it with the payload word at the same position. For a plain opcode it writes the payload to the controller register at that byte offset. For a transmit-data opcode it first waits for a transmit-class interrupt. For a receive-data opcode it waits for a receive-class interrupt and a non-empty receive FIFO, then reads the controller and stores the value in the payload slot.

The controller's interrupt status is sorted by three programmable masks: the unexpected mask, the transmit mask and the FIFO-watch mask. An unexpected event aborts the batch, captures the interrupt status and leaves the bus semaphore held, so that software can recover. A normal end runs an optional stop write, clears the controller's interrupt status, optionally releases the semaphore and then raises a completion flag.

Top module: `cmd_batch_engine`

## Requirements
- R1: After reset the status word (config word 0x01) reads 0x10: bit 0 done = 0, bit 1 unexpected = 0, bits 17:4 the one-hot state with idle at bit 4, and bit 20 lock = 0. Every opcode word (config words 0x10..0x16) reads 0xFFFFFFFF, and the irq output is 0.
- R2: In the control word (0x00), bit 0 is the enable. The engine moves from idle (status bit 4) to init (status bit 5) while the enable is 1. Writing 0 to the control word returns the engine to idle from any state, including the interrupt wait (status bit 8).
- R3: Control bit 1 pulses start while the engine is in init. Opcodes run in order: byte 0 of opcode word 0 first, byte 0 of the next word after byte 3. Opcode 0xFF ends the batch. Each plain opcode writes the payload word at its position (config words 0x20..0x38) to the controller at that byte offset.
- R4: Opcode 0x34 (transmit data) holds in the interrupt wait until a controller interrupt bit is set that is also set in the transmit mask (0x04) and clear in the unexpected mask (0x03). It then writes its payload to offset 0x34.
- R5: Opcode 0x38 (receive data) waits for an interrupt bit that is clear in both the transmit mask and the unexpected mask. While a FIFO status bit selected by the FIFO-watch mask (0x05) is set (FIFO empty), it keeps waiting. Otherwise it reads offset 0x38 and overwrites that payload slot with the value read, and it writes nothing to the controller for that entry.
- R6: While waiting for an interrupt, any controller interrupt bit that is set in the unexpected mask stops the batch in the unexpected state (status bit 17). Status bit 1 is set, the interrupt status is captured in word 0x07, lock stays 1, and no further controller writes take place.
- R7: Valid opcodes are 0x00, 0x04, 0x08, 0x0C, 0x10, 0x30, 0x34, 0x38, 0x44 and 0x48. Any other value except 0xFF sets the unexpected bit without a controller access.
- R8: If 25 entries have run without reaching 0xFF, the engine sets the unexpected bit instead of running a 26th entry.
- R9: At a normal end the engine writes 0 to offset 0x00 (the stop), then 0xFFFFFFFF to offset 0x10, then releases the lock. Bit 0 of word 0x06 skips the stop write, and bit 1 skips the lock release.
- R10: Status bit 0 is set at a normal end. Bits 0 and 1 are cleared by writing 1 to them. The irq output is 1 exactly when bit 0 of word 0x02 is 1 and status bit 0 or bit 1 is 1.
- R11: Lock (status bit 20) is set when a batch starts. Writing 1 to bit 0 of word 0x08 clears it.
- R12: Writing control bit 2 while the engine is waiting for an interrupt asserts ip_rst for exactly one cycle, and the engine then goes back to waiting. In any other state the write has no effect on ip_rst.
- R13: Control bit 3 returns the engine to idle and clears the enable, the lock and both status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| ip_wr | output | 1 | Controller register write strobe |
| ip_rd | output | 1 | Controller register read strobe |
| ip_addr | output | 8 | Controller register byte offset |
| ip_wdata | output | 32 | Controller write data |
| ip_rdata | input | 32 | Controller read data |
| ip_irq_stat | input | 32 | Controller interrupt status lines |
| ip_fifo_stat | input | 32 | Controller FIFO status lines |
| ip_rst | output | 1 | Reset pulse to the controller |
| irq | output | 1 | Batch completion or unexpected-event interrupt |

## Verification
If the entry index goes wrong, the sequence of controller writes shows it at once: an offset or payload comes out in the wrong place, or an extra write appears after a batch has ended or aborted. A fault in the interrupt sorting shows up within a few cycles, either as an entry that never leaves the interrupt wait or as one that leaves too early. The one-hot state bits and the lock bit in the status word make a wrong state visible as soon as the port reads it back.

// File: rtl/cbe_pkg.sv
package cbe_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_INIT, ST_GETSEM, ST_CONFIG, ST_WAIT, ST_IPRST, ST_ROUTE,
    ST_TXWR, ST_RXRD, ST_STOP, ST_CLEAN, ST_RELSEM, ST_GENINT, ST_UNEXP
  } cbe_state_e;

  localparam int NUM_STATES = 14;

  localparam logic [7:0] OP_END         = 8'hFF;
  localparam logic [7:0] IP_CTRL_OFF    = 8'h00;
  localparam logic [7:0] IP_INTSTAT_OFF = 8'h10;
  localparam logic [7:0] IP_TXDATA_OFF  = 8'h34;
  localparam logic [7:0] IP_RXDATA_OFF  = 8'h38;

  localparam logic [5:0] A_CTRL    = 6'h00;
  localparam logic [5:0] A_STAT    = 6'h01;
  localparam logic [5:0] A_IRQEN   = 6'h02;
  localparam logic [5:0] A_UMASK   = 6'h03;
  localparam logic [5:0] A_TXMASK  = 6'h04;
  localparam logic [5:0] A_RXFMASK = 6'h05;
  localparam logic [5:0] A_FSMCFG  = 6'h06;
  localparam logic [5:0] A_CAPT    = 6'h07;
  localparam logic [5:0] A_SEMREL  = 6'h08;
  localparam logic [5:0] A_OPBASE  = 6'h10;
  localparam logic [5:0] A_PAYBASE = 6'h20;

  function automatic logic op_is_valid(input logic [7:0] op);
    case (op)
      8'h00, 8'h04, 8'h08, 8'h0C, 8'h10,
      8'h30, 8'h34, 8'h38, 8'h44, 8'h48: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cbe_route.sv
module cbe_route #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] irq_stat,
  input  logic [DW-1:0] fifo_stat,
  input  logic [DW-1:0] umask,
  input  logic [DW-1:0] txmask,
  input  logic [DW-1:0] rxfmask,
  output logic          unexp_hit,
  output logic          tx_hit,
  output logic          rx_hit,
  output logic          rx_empty
);
  logic [DW-1:0] unexp_v, tx_v, rx_v;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign unexp_v[b] = irq_stat[b] & umask[b];
    assign tx_v[b]    = irq_stat[b] & ~umask[b] & txmask[b];
    assign rx_v[b]    = irq_stat[b] & ~umask[b] & ~txmask[b];
  end

  assign unexp_hit = |unexp_v;
  assign tx_hit    = |tx_v;
  assign rx_hit    = |rx_v;
  assign rx_empty  = |(fifo_stat & rxfmask);
endmodule

// File: rtl/cbe_regs.sv
module cbe_regs
  import cbe_pkg::*;
#(
  parameter int DW        = 32,
  parameter int OP_WORDS  = 7,
  parameter int PAY_WORDS = 25,
  parameter int EW        = $clog2(PAY_WORDS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [5:0]            cfg_addr,
  input  logic [DW-1:0]         cfg_wdata,
  output logic [DW-1:0]         cfg_rdata,
  output logic                  en,
  output logic                  start_p,
  output logic                  iprst_p,
  output logic                  selfrst_p,
  output logic                  semrel_p,
  output logic                  irq_en,
  output logic [DW-1:0]         umask,
  output logic [DW-1:0]         txmask,
  output logic [DW-1:0]         rxfmask,
  output logic                  skip_stop,
  output logic                  skip_rel,
  input  logic [EW-1:0]         idx,
  output logic [7:0]            op_byte,
  output logic [DW-1:0]         pay_word,
  input  logic                  wb_en,
  input  logic [DW-1:0]         wb_data,
  input  logic                  done_set,
  input  logic                  unexp_set,
  input  logic [DW-1:0]         cap_data,
  input  logic [NUM_STATES-1:0] state_oh,
  input  logic                  lock,
  output logic                  done,
  output logic                  unexp
);
  localparam int OW = (OP_WORDS > 1) ? $clog2(OP_WORDS) : 1;
  localparam int PW = (PAY_WORDS > 1) ? $clog2(PAY_WORDS) : 1;

  logic [DW-1:0] op_tab  [OP_WORDS];
  logic [DW-1:0] pay_tab [PAY_WORDS];
  logic [1:0]    fsmcfg_q;
  logic [DW-1:0] capt_q;

  logic ctrl_we, stat_we, op_we, pay_we;
  logic [OW-1:0] op_sel;
  logic [PW-1:0] pay_sel;
  logic done_d, unexp_d;

  assign ctrl_we   = cfg_we && (cfg_addr == A_CTRL);
  assign stat_we   = cfg_we && (cfg_addr == A_STAT);
  assign op_we     = cfg_we && (int'(cfg_addr) >= int'(A_OPBASE)) &&
                     (int'(cfg_addr) < int'(A_OPBASE) + OP_WORDS);
  assign pay_we    = cfg_we && (int'(cfg_addr) >= int'(A_PAYBASE)) &&
                     (int'(cfg_addr) < int'(A_PAYBASE) + PAY_WORDS);
  assign op_sel    = OW'(cfg_addr - A_OPBASE);
  assign pay_sel   = PW'(cfg_addr - A_PAYBASE);

  assign start_p   = ctrl_we && cfg_wdata[1];
  assign iprst_p   = ctrl_we && cfg_wdata[2];
  assign selfrst_p = ctrl_we && cfg_wdata[3];
  assign semrel_p  = cfg_we && (cfg_addr == A_SEMREL) && cfg_wdata[0];
  assign skip_stop = fsmcfg_q[0];
  assign skip_rel  = fsmcfg_q[1];

  // status flag next values: set wins over write-one-to-clear
  always_comb begin
    done_d  = done;
    unexp_d = unexp;
    if (stat_we && cfg_wdata[0]) done_d  = 1'b0;
    if (stat_we && cfg_wdata[1]) unexp_d = 1'b0;
    if (done_set)                done_d  = 1'b1;
    if (unexp_set)               unexp_d = 1'b1;
    if (selfrst_p) begin
      done_d  = 1'b0;
      unexp_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      irq_en   <= 1'b0;
      umask    <= '0;
      txmask   <= '0;
      rxfmask  <= '0;
      fsmcfg_q <= '0;
      capt_q   <= '0;
      done     <= 1'b0;
      unexp    <= 1'b0;
    end else begin
      if (ctrl_we) en <= cfg_wdata[0] & ~cfg_wdata[3];
      if (cfg_we && cfg_addr == A_IRQEN)   irq_en   <= cfg_wdata[0];
      if (cfg_we && cfg_addr == A_UMASK)   umask    <= cfg_wdata;
      if (cfg_we && cfg_addr == A_TXMASK)  txmask   <= cfg_wdata;
      if (cfg_we && cfg_addr == A_RXFMASK) rxfmask  <= cfg_wdata;
      if (cfg_we && cfg_addr == A_FSMCFG)  fsmcfg_q <= cfg_wdata[1:0];
      if (unexp_set)                       capt_q   <= cap_data;
      done  <= done_d;
      unexp <= unexp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < OP_WORDS; i++) op_tab[i] <= '1;
    end else if (op_we) begin
      op_tab[op_sel] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAY_WORDS; i++) pay_tab[i] <= '0;
    end else begin
      for (int i = 0; i < PAY_WORDS; i++) begin
        if (wb_en && int'(idx) == i)          pay_tab[i] <= wb_data;
        else if (pay_we && int'(pay_sel) == i) pay_tab[i] <= cfg_wdata;
      end
    end
  end

  // opcode stream: byte 0 of word 0 first
  always_comb begin
    op_byte = OP_END;
    if (int'(idx) < OP_WORDS * 4)
      op_byte = op_tab[idx[EW-1:2]][{idx[1:0], 3'b000} +: 8];
  end

  assign pay_word = (int'(idx) < PAY_WORDS) ? pay_tab[idx] : '0;

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == A_CTRL) begin
      cfg_rdata[0] = en;
    end else if (cfg_addr == A_STAT) begin
      cfg_rdata[0] = done;
      cfg_rdata[1] = unexp;
      cfg_rdata[4 +: NUM_STATES] = state_oh;
      cfg_rdata[20] = lock;
    end else if (cfg_addr == A_IRQEN) begin
      cfg_rdata[0] = irq_en;
    end else if (cfg_addr == A_UMASK) begin
      cfg_rdata = umask;
    end else if (cfg_addr == A_TXMASK) begin
      cfg_rdata = txmask;
    end else if (cfg_addr == A_RXFMASK) begin
      cfg_rdata = rxfmask;
    end else if (cfg_addr == A_FSMCFG) begin
      cfg_rdata[1:0] = fsmcfg_q;
    end else if (cfg_addr == A_CAPT) begin
      cfg_rdata = capt_q;
    end else if ((int'(cfg_addr) >= int'(A_OPBASE)) &&
                 (int'(cfg_addr) < int'(A_OPBASE) + OP_WORDS)) begin
      cfg_rdata = op_tab[op_sel];
    end else if ((int'(cfg_addr) >= int'(A_PAYBASE)) &&
                 (int'(cfg_addr) < int'(A_PAYBASE) + PAY_WORDS)) begin
      cfg_rdata = pay_tab[pay_sel];
    end
  end

  // R10: completion flag only rises after the generate-interrupt state
  assert_done_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state_oh[ST_GENINT]));

  // R6: the unexpected flag is only set through the sequencer's abort path
  assert_unexp_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unexp) |-> $past(unexp_set));
endmodule

// File: rtl/cbe_seq.sv
module cbe_seq
  import cbe_pkg::*;
#(
  parameter int DW        = 32,
  parameter int PAY_WORDS = 25,
  parameter int EW        = $clog2(PAY_WORDS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  start_p,
  input  logic                  iprst_p,
  input  logic                  selfrst_p,
  input  logic                  semrel_p,
  input  logic                  skip_stop,
  input  logic                  skip_rel,
  input  logic [7:0]            op_byte,
  input  logic [DW-1:0]         pay_word,
  input  logic                  unexp_hit,
  input  logic                  tx_hit,
  input  logic                  rx_hit,
  input  logic                  rx_empty,
  input  logic [DW-1:0]         irq_stat,
  input  logic [DW-1:0]         ip_rdata,
  output logic [EW-1:0]         idx,
  output logic                  wb_en,
  output logic [DW-1:0]         wb_data,
  output logic                  done_set,
  output logic                  unexp_set,
  output logic [DW-1:0]         cap_data,
  output logic [NUM_STATES-1:0] state_oh,
  output logic                  lock,
  output logic                  ip_wr,
  output logic                  ip_rd,
  output logic [7:0]            ip_addr,
  output logic [DW-1:0]         ip_wdata,
  output logic                  ip_rst
);
  cbe_state_e st_q, st_d;
  logic [EW-1:0] idx_q, idx_d;
  logic lock_q, lock_d;

  logic is_end, is_tx, is_rx, is_bad, is_full, plain_wr;

  assign is_end   = (op_byte == OP_END);
  assign is_tx    = (op_byte == IP_TXDATA_OFF);
  assign is_rx    = (op_byte == IP_RXDATA_OFF);
  assign is_full  = (int'(idx_q) >= PAY_WORDS);
  assign is_bad   = !op_is_valid(op_byte);
  assign plain_wr = (st_q == ST_CONFIG) && !is_end && !is_full && !is_bad &&
                    !is_tx && !is_rx;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    case (st_q)
      ST_IDLE:   if (en) st_d = ST_INIT;
      ST_INIT:   if (start_p) st_d = ST_GETSEM;
      ST_GETSEM: begin
        st_d  = ST_CONFIG;
        idx_d = '0;
      end
      ST_CONFIG: begin
        if (is_end)               st_d = skip_stop ? ST_CLEAN : ST_STOP;
        else if (is_full)         st_d = ST_UNEXP;
        else if (is_bad)          st_d = ST_UNEXP;
        else if (is_tx || is_rx)  st_d = ST_WAIT;
        else                      idx_d = idx_q + 1'b1;
      end
      ST_WAIT: begin
        if (unexp_hit)                   st_d = ST_UNEXP;
        else if (iprst_p)                st_d = ST_IPRST;
        else if (is_tx ? tx_hit : rx_hit) st_d = ST_ROUTE;
      end
      ST_IPRST:  st_d = ST_WAIT;
      ST_ROUTE: begin
        if (is_tx)         st_d = ST_TXWR;
        else if (rx_empty) st_d = ST_WAIT;
        else               st_d = ST_RXRD;
      end
      ST_TXWR, ST_RXRD: begin
        st_d  = ST_CONFIG;
        idx_d = idx_q + 1'b1;
      end
      ST_STOP:   st_d = ST_CLEAN;
      ST_CLEAN:  st_d = skip_rel ? ST_GENINT : ST_RELSEM;
      ST_RELSEM: st_d = ST_GENINT;
      ST_GENINT: st_d = ST_INIT;
      ST_UNEXP:  st_d = ST_UNEXP;
      default:   st_d = ST_IDLE;
    endcase
    if (!en || selfrst_p) st_d = ST_IDLE;
  end

  always_comb begin
    lock_d = lock_q;
    if (st_q == ST_GETSEM) lock_d = 1'b1;
    if (st_q == ST_RELSEM || semrel_p) lock_d = 1'b0;
    if (selfrst_p) lock_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      lock_q <= lock_d;
    end
  end

  always_comb begin
    ip_wr    = 1'b0;
    ip_addr  = op_byte;
    ip_wdata = pay_word;
    if (plain_wr || st_q == ST_TXWR) begin
      ip_wr = 1'b1;
    end else if (st_q == ST_STOP) begin
      ip_wr    = 1'b1;
      ip_addr  = IP_CTRL_OFF;
      ip_wdata = '0;
    end else if (st_q == ST_CLEAN) begin
      ip_wr    = 1'b1;
      ip_addr  = IP_INTSTAT_OFF;
      ip_wdata = '1;
    end
  end

  assign ip_rd     = (st_q == ST_RXRD);
  assign ip_rst    = (st_q == ST_IPRST);
  assign wb_en     = (st_q == ST_RXRD);
  assign wb_data   = ip_rdata;
  assign done_set  = (st_q == ST_GENINT);
  assign unexp_set = (st_d == ST_UNEXP) && (st_q != ST_UNEXP);
  assign cap_data  = irq_stat;
  assign idx       = idx_q;
  assign lock      = lock_q;
  assign state_oh  = NUM_STATES'(1) << st_q;

  // R6: an unexpected interrupt during the wait aborts on the next edge
  assert_wait_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && unexp_hit && en && !selfrst_p) |=> (st_q == ST_UNEXP));

  // R5: the controller is never read and written in the same cycle
  assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ip_wr && ip_rd));

  // R12: the controller reset pulse only follows the interrupt wait
  assert_iprst_from_wait_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ip_rst |-> ($past(st_q) == ST_WAIT) && !$past(ip_rst));

  // R8: the entry index never runs past the payload table
  assert_idx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) <= PAY_WORDS);

  // R11: the release state always frees the semaphore
  assert_lock_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RELSEM) |=> !lock_q);

  // R4: transmit data is written only after an interrupt was routed
  assert_tx_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TXWR) |-> ($past(st_q) == ST_ROUTE) && $past(tx_hit));
endmodule

// File: rtl/cmd_batch_engine.sv
module cmd_batch_engine
  import cbe_pkg::*;
#(
  parameter int DW        = 32,
  parameter int OP_WORDS  = 7,
  parameter int PAY_WORDS = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [5:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          ip_wr,
  output logic          ip_rd,
  output logic [7:0]    ip_addr,
  output logic [DW-1:0] ip_wdata,
  input  logic [DW-1:0] ip_rdata,
  input  logic [DW-1:0] ip_irq_stat,
  input  logic [DW-1:0] ip_fifo_stat,
  output logic          ip_rst,
  output logic          irq
);
  localparam int EW = $clog2(PAY_WORDS + 1);

  logic en, start_p, iprst_p, selfrst_p, semrel_p, irq_en, skip_stop, skip_rel;
  logic [DW-1:0] umask, txmask, rxfmask, pay_word, wb_data, cap_data;
  logic [EW-1:0] idx;
  logic [7:0] op_byte;
  logic wb_en, done_set, unexp_set, lock, done, unexp;
  logic unexp_hit, tx_hit, rx_hit, rx_empty;
  logic [NUM_STATES-1:0] state_oh;

  cbe_regs #(.DW(DW), .OP_WORDS(OP_WORDS), .PAY_WORDS(PAY_WORDS), .EW(EW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .en(en), .start_p(start_p),
    .iprst_p(iprst_p), .selfrst_p(selfrst_p), .semrel_p(semrel_p),
    .irq_en(irq_en), .umask(umask), .txmask(txmask), .rxfmask(rxfmask),
    .skip_stop(skip_stop), .skip_rel(skip_rel), .idx(idx), .op_byte(op_byte),
    .pay_word(pay_word), .wb_en(wb_en), .wb_data(wb_data), .done_set(done_set),
    .unexp_set(unexp_set), .cap_data(cap_data), .state_oh(state_oh),
    .lock(lock), .done(done), .unexp(unexp)
  );

  cbe_route #(.DW(DW)) u_route (
    .irq_stat(ip_irq_stat), .fifo_stat(ip_fifo_stat), .umask(umask),
    .txmask(txmask), .rxfmask(rxfmask), .unexp_hit(unexp_hit),
    .tx_hit(tx_hit), .rx_hit(rx_hit), .rx_empty(rx_empty)
  );

  cbe_seq #(.DW(DW), .PAY_WORDS(PAY_WORDS), .EW(EW)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .start_p(start_p), .iprst_p(iprst_p),
    .selfrst_p(selfrst_p), .semrel_p(semrel_p), .skip_stop(skip_stop),
    .skip_rel(skip_rel), .op_byte(op_byte), .pay_word(pay_word),
    .unexp_hit(unexp_hit), .tx_hit(tx_hit), .rx_hit(rx_hit),
    .rx_empty(rx_empty), .irq_stat(ip_irq_stat), .ip_rdata(ip_rdata),
    .idx(idx), .wb_en(wb_en), .wb_data(wb_data), .done_set(done_set),
    .unexp_set(unexp_set), .cap_data(cap_data), .state_oh(state_oh),
    .lock(lock), .ip_wr(ip_wr), .ip_rd(ip_rd), .ip_addr(ip_addr),
    .ip_wdata(ip_wdata), .ip_rst(ip_rst)
  );

  assign irq = irq_en & (done | unexp);

  // R10: the interrupt output drops once both flags are clear
  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !unexp) |-> !irq);
endmodule

// File: tb/sim_cmd_batch_engine.sv
`timescale 1ns/1ps
module sim_cmd_batch_engine;
  import cbe_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ip_wr, ip_rd, ip_rst, irq;
  logic [7:0]  ip_addr;
  logic [31:0] ip_wdata;
  logic [31:0] ip_rdata = '0;
  logic [31:0] ip_irq_stat = '0;
  logic [31:0] ip_fifo_stat = '0;

  cmd_batch_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ip_wr(ip_wr), .ip_rd(ip_rd),
    .ip_addr(ip_addr), .ip_wdata(ip_wdata), .ip_rdata(ip_rdata),
    .ip_irq_stat(ip_irq_stat), .ip_fifo_stat(ip_fifo_stat), .ip_rst(ip_rst),
    .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // controller-side monitor
  logic [7:0]  log_a [256];
  logic [31:0] log_d [256];
  int log_n = 0;
  int rst_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && ip_wr) begin
      log_a[log_n % 256] = ip_addr;
      log_d[log_n % 256] = ip_wdata;
      log_n = log_n + 1;
    end
    if (rst_n && ip_rst) rst_cnt = rst_cnt + 1;
  end

  logic [7:0]  bop  [28];
  logic [31:0] bpay [25];
  logic [7:0]  exp_a [64];
  logic [31:0] exp_d [64];
  int exp_n;
  logic [7:0] plain_ops [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h30, 8'h44, 8'h48};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic clear_ops();
    for (int i = 0; i < 28; i++) bop[i] = 8'hFF;
    for (int i = 0; i < 25; i++) bpay[i] = 32'h0;
  endtask

  task automatic load_tables();
    for (int w = 0; w < 7; w++)
      wr(6'(A_OPBASE + w), {bop[4*w+3], bop[4*w+2], bop[4*w+1], bop[4*w]});
    for (int p = 0; p < 25; p++) wr(6'(A_PAYBASE + p), bpay[p]);
  endtask

  task automatic launch(output int base);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h3);
    base = log_n;
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h3);
  endtask

  task automatic wait_end(output logic [31:0] s);
    for (int c = 0; c < 600; c++) begin
      rd(A_STAT, s);
      if (s[1:0] != 2'b00) break;
    end
  endtask

  // expected controller writes for a batch that ends normally
  task automatic build_exp(input bit skip_stop);
    exp_n = 0;
    for (int i = 0; i < 25; i++) begin
      if (bop[i] == 8'hFF) break;
      if (bop[i] != 8'h38) begin
        exp_a[exp_n] = bop[i]; exp_d[exp_n] = bpay[i]; exp_n++;
      end
    end
    if (!skip_stop) begin exp_a[exp_n] = 8'h00; exp_d[exp_n] = 32'h0; exp_n++; end
    exp_a[exp_n] = 8'h10; exp_d[exp_n] = 32'hFFFFFFFF; exp_n++;
  endtask

  task automatic check_log(input int base, input string req);
    chk(log_n - base == exp_n, {req, " write count"}, 32'(log_n - base), 32'(exp_n));
    for (int i = 0; i < exp_n && i < log_n - base; i++)
      chk(log_a[(base+i)%256] == exp_a[i] && log_d[(base+i)%256] == exp_d[i],
          {req, " write entry"}, {log_a[(base+i)%256], log_d[(base+i)%256][23:0]},
          {exp_a[i], exp_d[i][23:0]});
  endtask

  initial begin
    logic [31:0] s;
    int base;
    int rb;
    void'($urandom(32'd20240611));
    clear_ops();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    rd(A_STAT, s);
    chk(s == 32'h10, "R1 status after reset", s, 32'h10);
    rd(A_OPBASE, s);
    chk(s == 32'hFFFFFFFF, "R1 opcode word reset", s, 32'hFFFFFFFF);
    rd(6'(A_OPBASE + 6), s);
    chk(s == 32'hFFFFFFFF, "R1 last opcode word reset", s, 32'hFFFFFFFF);
    chk(irq == 1'b0, "R1 irq after reset", {31'b0, irq}, 32'h0);

    wr(A_UMASK, 32'h0000000E);
    wr(A_TXMASK, 32'h00000011);
    wr(A_RXFMASK, 32'h00000040);
    wr(A_IRQEN, 32'h1);

    // R2: enable moves to init
    wr(A_CTRL, 32'h1);
    repeat (2) @(negedge clk);
    rd(A_STAT, s);
    chk(s[17:4] == 14'h0002, "R2 init after enable", s, 32'h20);

    // R3 R9 R10 R11: directed batch
    clear_ops();
    bop[0] = 8'h04; bop[1] = 8'h08; bop[2] = 8'h0C;
    bpay[0] = 32'hCAFE0001; bpay[1] = 32'hCAFE0002; bpay[2] = 32'hCAFE0003;
    load_tables();
    launch(base);
    wait_end(s);
    build_exp(1'b0);
    check_log(base, "R3 R9 directed batch");
    chk(s[0] == 1'b1 && s[1] == 1'b0, "R10 done set", s, 32'h1);
    chk(s[20] == 1'b0, "R11 lock released at end", s, 32'h0);
    chk(irq == 1'b1, "R10 irq on done", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, s);
    chk(s[0] == 1'b0 && irq == 1'b0, "R10 done W1C", s, 32'h0);

    // R3: random batches of plain writes
    for (int t = 0; t < 20; t++) begin
      int len;
      clear_ops();
      len = 1 + int'($urandom % 24);
      for (int i = 0; i < len; i++) begin
        bop[i] = plain_ops[$urandom % 8];
        bpay[i] = $urandom;
      end
      load_tables();
      launch(base);
      wait_end(s);
      build_exp(1'b0);
      check_log(base, "R3 random batch");
      chk(s[1:0] == 2'b01, "R3 random batch done", s, 32'h1);
    end

    // R4: transmit entry waits for a transmit interrupt
    clear_ops();
    bop[0] = 8'h34; bpay[0] = 32'h000000A5;
    load_tables();
    launch(base);
    repeat (20) @(negedge clk);
    rd(A_STAT, s);
    chk(s[17:4] == 14'h0010, "R4 holds in wait", s, 32'h100);
    chk(log_n == base, "R4 no write before interrupt", 32'(log_n - base), 32'h0);
    ip_irq_stat = 32'h00000001;
    wait_end(s);
    ip_irq_stat = 32'h0;
    build_exp(1'b0);
    check_log(base, "R4 transmit write");

    // R5: receive entry, FIFO empty then filled
    clear_ops();
    bop[0] = 8'h38; bpay[0] = 32'h00000011;
    load_tables();
    ip_irq_stat = 32'h00000100;
    ip_fifo_stat = 32'h00000040;
    ip_rdata = 32'h5A5A1234;
    launch(base);
    repeat (20) @(negedge clk);
    rd(A_STAT, s);
    chk(s[1:0] == 2'b00, "R5 waits while FIFO empty", s, 32'h0);
    rd(A_PAYBASE, s);
    chk(s == 32'h00000011, "R5 slot untouched while empty", s, 32'h11);
    ip_fifo_stat = 32'h0;
    wait_end(s);
    ip_irq_stat = 32'h0;
    chk(s[1:0] == 2'b01, "R5 receive batch done", s, 32'h1);
    rd(A_PAYBASE, s);
    chk(s == 32'h5A5A1234, "R5 slot holds read data", s, 32'h5A5A1234);
    build_exp(1'b0);
    check_log(base, "R5 no write for receive entry");

    // R6 R11: unexpected interrupt during wait
    clear_ops();
    bop[0] = 8'h34; bop[1] = 8'h04;
    load_tables();
    ip_irq_stat = 32'h00000003;
    launch(base);
    wait_end(s);
    repeat (5) @(negedge clk);
    rd(A_STAT, s);
    chk(s[1:0] == 2'b10 && s[17] == 1'b1, "R6 unexpected state", s, 32'h20002);
    chk(s[20] == 1'b1, "R6 lock stays held", s, 32'h100000);
    chk(log_n == base, "R6 no writes after abort", 32'(log_n - base), 32'h0);
    rd(A_CAPT, s);
    chk(s == 32'h00000003, "R6 captured status", s, 32'h3);
    chk(irq == 1'b1, "R10 irq on unexpected", {31'b0, irq}, 32'h1);
    ip_irq_stat = 32'h0;
    wr(A_SEMREL, 32'h1);
    rd(A_STAT, s);
    chk(s[20] == 1'b0, "R11 software release", s, 32'h0);
    wr(A_STAT, 32'h2);
    chk(irq == 1'b0, "R10 unexpected W1C", {31'b0, irq}, 32'h0);

    // R7 R13: invalid opcode then self reset
    clear_ops();
    bop[0] = 8'h05;
    load_tables();
    launch(base);
    wait_end(s);
    chk(s[1:0] == 2'b10, "R7 invalid opcode aborts", s, 32'h2);
    chk(log_n == base, "R7 no controller write", 32'(log_n - base), 32'h0);
    wr(A_CTRL, 32'h9);
    rd(A_STAT, s);
    chk(s == 32'h10, "R13 self reset to idle", s, 32'h10);
    rd(A_CTRL, s);
    chk(s[0] == 1'b0, "R13 enable cleared", s, 32'h0);

    // R8: 25 entries without end marker
    clear_ops();
    for (int i = 0; i < 28; i++) bop[i] = 8'h04;
    for (int i = 0; i < 25; i++) bpay[i] = 32'h100 + 32'(i);
    load_tables();
    launch(base);
    wait_end(s);
    chk(s[1:0] == 2'b10, "R8 overflow aborts", s, 32'h2);
    chk(log_n - base == 25, "R8 write count", 32'(log_n - base), 32'd25);
    rb = (log_n - 1) % 256;
    chk(log_d[rb] == 32'h118, "R8 last payload", log_d[rb], 32'h118);
    wr(A_CTRL, 32'h8);

    // R9: skip stop and skip release
    wr(A_FSMCFG, 32'h3);
    clear_ops();
    bop[0] = 8'h08; bpay[0] = 32'h77;
    load_tables();
    launch(base);
    wait_end(s);
    build_exp(1'b1);
    check_log(base, "R9 skip stop");
    chk(s[20] == 1'b1, "R9 lock kept with skip release", s, 32'h100000);
    wr(A_SEMREL, 32'h1);
    wr(A_FSMCFG, 32'h0);

    // R12 R2: controller reset pulse in wait, force idle
    clear_ops();
    bop[0] = 8'h34;
    load_tables();
    launch(base);
    repeat (10) @(negedge clk);
    rb = rst_cnt;
    wr(A_CTRL, 32'h5);
    repeat (5) @(negedge clk);
    chk(rst_cnt - rb == 1, "R12 one reset pulse", 32'(rst_cnt - rb), 32'h1);
    rd(A_STAT, s);
    chk(s[17:4] == 14'h0010, "R12 back to wait", s, 32'h100);
    wr(A_CTRL, 32'h0);
    rd(A_STAT, s);
    chk(s[17:4] == 14'h0001, "R2 forced idle from wait", s, 32'h10);
    wr(A_CTRL, 32'h1);
    repeat (3) @(negedge clk);
    rb = rst_cnt;
    wr(A_CTRL, 32'h5);
    repeat (5) @(negedge clk);
    chk(rst_cnt == rb, "R12 ignored outside wait", 32'(rst_cnt - rb), 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule